// File: doc/BRIEF.md
# Vector-Pull Aware Chip-Select Decoder

This block produces the chip selects for a small 8-bit processor system with a 16-bit address bus. The low half of the map goes to RAM and the upper half goes to nonvolatile ROM. Most of the top 256-byte page is taken from ROM and split into equal I/O slots, so the memory-mapped peripherals sit in that page. The last six bytes of the page hold the processor's vector words, and they stay on ROM.

The processor drives an active-low vector-pull line during the last cycles of every interrupt sequence, while it reads the vector bytes. Reset counts as one of these sequences. While that line is low, the decoder routes every access in the top page to ROM, so the boot and interrupt vectors always come from memory and never from a peripheral. During the same vector fetch, the decoder can also rewrite a small field of the address it passes on to memory. The new field holds the number of the highest-priority pending interrupt source, so each source can fetch its own vector.

All outputs are registered. They take new values only on clock edges where the bus-phase qualifier is high, which gives them a latency of one qualified edge.

Top module: `vpull_cs_decoder`

## Requirements
- R1: While `rst_n` is low, all selects are inactive and `mem_addr` is 16'h0000.
- R2: Addresses 16'h0000–16'h7FFF assert `sel_ram` for both reads (`rw_n`=1) and writes (`rw_n`=0).
- R3: Reads from 16'h8000–16'hFEFF and from 16'hFFFA–16'hFFFF assert `sel_rom`, whatever the level of `vp_n`.
- R4: A write (`rw_n`=0) to any address that would otherwise select ROM asserts no select at all. This includes the top page while `vp_n` is low.
- R5: With `vp_n` high, an access to 16'hFF00–16'hFFF9 asserts exactly bit `sel_io[addr[7:5]]`, for both reads and writes. Slot 7 covers 16'hFFE0–16'hFFF9.
- R6: With `vp_n` low, a read anywhere in 16'hFF00–16'hFFFF asserts `sel_rom` and no `sel_io` bit.
- R7: At most one select is active in any cycle. After a qualified read, exactly one is active. This holds for all 65536 addresses with `vp_n` at either level.
- R8: On an edge where `phi2_en` is low, every output keeps its value.
- R9: After a qualified edge, the outputs reflect the inputs sampled at that edge, and they hold those values until the next qualified edge.
- R10: If `vp_n` is low and `irq_pend` is nonzero, `mem_addr` equals `addr` with bits [3:1] replaced by the index of the lowest-numbered set bit of `irq_pend`. In every other case, `mem_addr` equals `addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| phi2_en | input | 1 | Bus-phase qualifier; the registers load only when it is high |
| addr | input | 16 | Processor address bus |
| rw_n | input | 1 | 1 = read, 0 = write |
| vp_n | input | 1 | Active-low vector-pull indication |
| irq_pend | input | 8 | Pending interrupt sources; bit 0 has the highest priority |
| sel_ram | output | 1 | RAM chip select, active high |
| sel_rom | output | 1 | ROM chip select, active high |
| sel_io | output | 8 | One-hot I/O slot selects |
| mem_addr | output | 16 | Address passed to memory, with the vector field possibly remapped |

## Verification
On every cycle, the embedded assertions check these properties:
- At most one select is active.
- Exactly one select follows a qualified read.
- A ROM-region write produces no select.
- A vector-pull read of the top page lands on ROM.
- The outputs hold on unqualified edges.
- The address passes through unchanged whenever `vp_n` is high.

The bench's scenarios are needed for the exact region boundaries, the choice of slot, the priority order of the remap, and the exhaustive sweep of both `vp_n` levels against a behavioural model.

// File: rtl/vpull_cs_pkg.sv
package vpull_cs_pkg;

    typedef enum logic [1:0] {
        RG_NONE = 2'd0,
        RG_RAM  = 2'd1,
        RG_ROM  = 2'd2,
        RG_IO   = 2'd3
    } region_e;

endpackage

// File: rtl/vpull_region_decode.sv
module vpull_region_decode
    import vpull_cs_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter int                NUM_IO    = 8,
    parameter int                SLOT_BITS = 5,
    parameter logic [ADDR_W-1:0] RAM_LAST  = 16'h7FFF,
    parameter logic [ADDR_W-1:0] IO_BASE   = 16'hFF00,
    parameter logic [ADDR_W-1:0] IO_LAST   = 16'hFFF9,
    localparam int               IO_IDX_W  = (NUM_IO > 1) ? $clog2(NUM_IO) : 1
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic                rw_n,
    input  logic                vp_n,
    output region_e             region,
    output logic [IO_IDX_W-1:0] slot
);

    logic [ADDR_W-1:0] io_off;
    logic              in_window;

    always_comb begin
        io_off    = addr - IO_BASE;
        in_window = (addr >= IO_BASE) && (addr <= IO_LAST);
        slot      = IO_IDX_W'(io_off >> SLOT_BITS);

        if (addr <= RAM_LAST) begin
            region = RG_RAM;
        end else if (in_window && vp_n) begin
            region = RG_IO;
        end else if (rw_n) begin
            region = RG_ROM;
        end else begin
            region = RG_NONE;
        end
    end

endmodule

// File: rtl/vpull_prio_enc.sv
module vpull_prio_enc #(
    parameter int  NUM_SRC = 8,
    localparam int SRC_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0] pend,
    output logic               any,
    output logic [SRC_W-1:0]   idx
);

    always_comb begin
        any = |pend;
        idx = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend[i]) begin
                idx = SRC_W'(i);
            end
        end
    end

endmodule

// File: rtl/vpull_cs_decoder.sv
module vpull_cs_decoder
    import vpull_cs_pkg::*;
#(
    parameter int  ADDR_W    = 16,
    parameter int  NUM_IO    = 8,
    parameter int  SLOT_BITS = 5,
    parameter int  NUM_SRC   = 8,
    parameter int  REMAP_LSB = 1,
    parameter bit  REMAP_EN  = 1'b1,
    localparam int IO_IDX_W  = (NUM_IO > 1) ? $clog2(NUM_IO) : 1,
    localparam int SRC_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               phi2_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               rw_n,
    input  logic               vp_n,
    input  logic [NUM_SRC-1:0] irq_pend,
    output logic               sel_ram,
    output logic               sel_rom,
    output logic [NUM_IO-1:0]  sel_io,
    output logic [ADDR_W-1:0]  mem_addr
);

    typedef struct packed {
        logic              ram;
        logic              rom;
        logic [NUM_IO-1:0] io;
        logic [ADDR_W-1:0] maddr;
    } out_t;

    region_e             region;
    logic [IO_IDX_W-1:0] slot;
    logic                src_any;
    logic [SRC_W-1:0]    src_idx;
    logic [NUM_IO-1:0]   io_hot;
    logic [ADDR_W-1:0]   maddr_c;
    out_t                st_d, st_q;

    vpull_region_decode #(
        .ADDR_W    (ADDR_W),
        .NUM_IO    (NUM_IO),
        .SLOT_BITS (SLOT_BITS)
    ) u_region (
        .addr   (addr),
        .rw_n   (rw_n),
        .vp_n   (vp_n),
        .region (region),
        .slot   (slot)
    );

    vpull_prio_enc #(
        .NUM_SRC (NUM_SRC)
    ) u_prio (
        .pend (irq_pend),
        .any  (src_any),
        .idx  (src_idx)
    );

    for (genvar g = 0; g < NUM_IO; g++) begin : g_io
        assign io_hot[g] = (region == RG_IO) && (slot == IO_IDX_W'(g));
    end

    if (REMAP_EN) begin : g_remap
        always_comb begin
            maddr_c = addr;
            if (!vp_n && src_any) begin
                maddr_c[REMAP_LSB +: SRC_W] = src_idx;
            end
        end
    end else begin : g_pass
        assign maddr_c = addr;
    end

    always_comb begin
        st_d = st_q;
        if (phi2_en) begin
            st_d.ram   = (region == RG_RAM);
            st_d.rom   = (region == RG_ROM);
            st_d.io    = io_hot;
            st_d.maddr = maddr_c;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_ram  = st_q.ram;
    assign sel_rom  = st_q.rom;
    assign sel_io   = st_q.io;
    assign mem_addr = st_q.maddr;

    // R7: never two selects together
    a_r7_at_most_one: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_ram, sel_rom, sel_io}));

    // R7: a qualified read always lands on exactly one device
    a_r7_read_hits_one: assert property (@(posedge clk) disable iff (!rst_n)
        (phi2_en && rw_n) |=> ($countones({sel_ram, sel_rom, sel_io}) == 1));

    // R4: writes above RAM outside the I/O window select nothing
    a_r4_rom_write_none: assert property (@(posedge clk) disable iff (!rst_n)
        (phi2_en && !rw_n && addr[ADDR_W-1] && !(vp_n && addr[ADDR_W-1:8] == '1 && addr[7:0] <= 8'hF9))
        |=> ({sel_ram, sel_rom, sel_io} == '0));

    // R6: vector-pull read in the top page goes to ROM
    a_r6_vpull_rom: assert property (@(posedge clk) disable iff (!rst_n)
        (phi2_en && rw_n && !vp_n && addr[ADDR_W-1:8] == '1) |=> (sel_rom && sel_io == '0));

    // R8: unqualified edges hold every output
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !phi2_en |=> ($stable(sel_ram) && $stable(sel_rom) && $stable(sel_io) && $stable(mem_addr)));

    // R10: no remap outside vector pulls
    a_r10_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (phi2_en && vp_n) |=> (mem_addr == $past(addr)));

endmodule

// File: tb/test_vpull_cs_decoder.sv
module test_vpull_cs_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        phi2_en = 1'b0;
    logic [15:0] addr = '0;
    logic        rw_n = 1'b1;
    logic        vp_n = 1'b1;
    logic [7:0]  irq_pend = '0;
    logic        sel_ram, sel_rom;
    logic [7:0]  sel_io;
    logic [15:0] mem_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference state
    logic        e_ram = 1'b0, e_rom = 1'b0;
    logic [7:0]  e_io = '0;
    logic [15:0] e_addr = '0;

    always #4 clk = ~clk;

    vpull_cs_decoder i_vpull_cs_decoder (
        .clk      (clk),
        .rst_n    (rst_n),
        .phi2_en  (phi2_en),
        .addr     (addr),
        .rw_n     (rw_n),
        .vp_n     (vp_n),
        .irq_pend (irq_pend),
        .sel_ram  (sel_ram),
        .sel_rom  (sel_rom),
        .sel_io   (sel_io),
        .mem_addr (mem_addr)
    );

    task automatic model_update();
        int a;
        a = int'(addr);
        if (!rst_n) begin
            e_ram = 0; e_rom = 0; e_io = '0; e_addr = '0;
        end else if (phi2_en) begin
            e_ram = 0; e_rom = 0; e_io = '0;
            if (a < 32768) e_ram = 1;
            else if (vp_n && a >= 'hFF00 && a <= 'hFFF9) e_io[(a - 'hFF00) / 32] = 1'b1;
            else if (rw_n) e_rom = 1;
            e_addr = addr;
            if (!vp_n && irq_pend != 0) begin
                int k;
                k = 0;
                while (!irq_pend[k]) k++;
                e_addr[3:1] = 3'(k);
            end
        end
    endtask

    task automatic compare(input string tag);
        checks++;
        if ({sel_ram, sel_rom, sel_io, mem_addr} !== {e_ram, e_rom, e_io, e_addr}) begin
            fails++;
            $display("FAIL %s addr=%h: got ram=%b rom=%b io=%b maddr=%h, expected ram=%b rom=%b io=%b maddr=%h",
                     tag, addr, sel_ram, sel_rom, sel_io, mem_addr, e_ram, e_rom, e_io, e_addr);
        end
    endtask

    // inputs are driven while clk is low; outputs compared on the next falling edge
    task automatic step(input logic [15:0] a, input logic r, input logic v,
                        input logic en, input logic [7:0] p, input string tag);
        addr = a; rw_n = r; vp_n = v; phi2_en = en; irq_pend = p;
        @(posedge clk);
        #1;
        model_update();
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        @(negedge clk);
        model_update();
        compare("R1 reset");
        step(16'h8000, 1, 1, 1, 8'h00, "R1 reset held");
        rst_n = 1'b1;

        // R2
        step(16'h0000, 1, 1, 1, 8'h00, "R2 ram low read");
        step(16'h7FFF, 0, 1, 1, 8'h00, "R2 ram top write");
        step(16'h7FFF, 1, 0, 1, 8'h00, "R2 ram read vp low");
        // R3
        step(16'h8000, 1, 1, 1, 8'h00, "R3 rom base");
        step(16'hFEFF, 1, 1, 1, 8'h00, "R3 rom below page");
        step(16'hFFFA, 1, 1, 1, 8'h00, "R3 vector vp high");
        step(16'hFFFF, 1, 0, 1, 8'h00, "R3 vector vp low");
        // R4
        step(16'h8000, 0, 1, 1, 8'h00, "R4 rom write");
        step(16'hFFFC, 0, 1, 1, 8'h00, "R4 vector write");
        step(16'hFF10, 0, 0, 1, 8'h00, "R4 page write vp low");
        // R5
        step(16'hFF00, 1, 1, 1, 8'h00, "R5 slot0 base");
        step(16'hFF1F, 0, 1, 1, 8'h00, "R5 slot0 top write");
        step(16'hFF20, 1, 1, 1, 8'h00, "R5 slot1 base");
        step(16'hFFE0, 1, 1, 1, 8'h00, "R5 slot7 base");
        step(16'hFFF9, 0, 1, 1, 8'h00, "R5 slot7 last");
        // R6
        step(16'hFF00, 1, 0, 1, 8'h00, "R6 page base vp low");
        step(16'hFFF9, 1, 0, 1, 8'h00, "R6 window end vp low");
        step(16'hFFFC, 1, 0, 1, 8'h00, "R6 reset vector");
        // R8 / R9
        step(16'hFF40, 1, 1, 1, 8'h00, "R9 qualified load");
        step(16'h1234, 0, 0, 0, 8'hFF, "R8 hold unqualified");
        step(16'h9000, 1, 1, 0, 8'h00, "R8 hold again");
        step(16'h9000, 1, 1, 1, 8'h00, "R9 load after hold");
        // R10
        step(16'hFFFE, 1, 0, 1, 8'h28, "R10 remap src3");
        checks++;
        if (mem_addr !== 16'hFFF6) begin
            fails++;
            $display("FAIL R10 literal: got %h expected FFF6", mem_addr);
        end
        step(16'hFFFE, 1, 0, 1, 8'h80, "R10 remap src7");
        step(16'hFFFA, 1, 0, 1, 8'h01, "R10 remap src0");
        step(16'hFFFE, 1, 0, 1, 8'h00, "R10 no pending");
        step(16'hFFFE, 1, 1, 1, 8'h28, "R10 vp high pass");
        // R7 exhaustive, both vp levels
        for (int v = 0; v < 2; v++) begin
            for (int a = 0; a < 65536; a++) begin
                step(16'(a), 1, 1'(v), 1, 8'h00, "R7 sweep");
                checks++;
                if ($countones({sel_ram, sel_rom, sel_io}) != 1) begin
                    fails++;
                    $display("FAIL R7 addr=%h vp=%0d: selects=%0d expected 1",
                             addr, v, $countones({sel_ram, sel_rom, sel_io}));
                end
            end
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule